// File: doc/BRIEF.md
# Home Request Serializer

This block sits in the home node of a coherent fabric and decides the order in which requests to the same cache line are broadcast. Several source nodes offer requests, either coherent reads or writebacks, each naming a line address. In every cycle at most one request is accepted, and it is sent out one cycle later as a forwarded snoop. That snoop carries the originating node's number, so that the snoopers know where their responses and data must go.

Once a line has been forwarded, it stays locked until the source node reports that it has collected every snoop response. Data still in flight for that line does not delay the release. The next request to that line can therefore start while the earlier transfer is still finishing. Lines that are not locked are never held back by a locked line.

Writebacks go through the same ordering stream as reads. The home also takes the writeback data, writes it to memory, and in the following cycle sends an acknowledgement to the writer.

Top module: `hrs_serializer`

## Requirements
- R1: While reset is low, and in the first cycle after it, `fwd_valid`, `mem_we` and `ack_valid` are 0. After reset no line is locked.
- R2: At most one bit of `req_ready` is high in any cycle. When source i is accepted, the next cycle shows `fwd_valid`=1 with `fwd_src`=i and the address and kind of that request.
- R3: A request to a line that is locked (forwarded and not yet released) is not accepted. The line is released at the clock edge where a completion notice (`cmp_valid`, `cmp_addr`) for that line is sampled, and a waiting request can be accepted in the next cycle.
- R4: A request to an unlocked line is accepted in the same cycle it is offered when no other eligible source has priority, even while other lines are locked.
- R5: Among sources with eligible requests, the winner is the first one in the cyclic order that starts just after the source last granted. After reset, source 0 has the highest priority.
- R6: A writeback request (`req_wb`=1) follows the same locking and arbitration as a read and is forwarded with `fwd_wb`=1.
- R7: Writeback data sampled at clock edge k is written to memory with `mem_we`=1, the same address and the same data in the cycle after edge k. An acknowledgement (`ack_valid`=1, `ack_dst` = writer) follows in the cycle after the write.
- R8: A completion notice releases only the line it names. A notice for an unlocked line changes nothing. When a notice and an acceptance name the same line in the same cycle, the line ends up locked.
- R9: `fwd_valid` is high only in the cycle that follows an acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | N_SRC | Request offered, one bit per source |
| req_addr | input | N_SRC*ADDR_W | Line address per source, source i in bits [i*ADDR_W +: ADDR_W] |
| req_wb | input | N_SRC | 1 = writeback, 0 = coherent read |
| req_ready | output | N_SRC | Request accepted this cycle (one-hot or zero) |
| fwd_valid | output | 1 | Forwarded snoop valid |
| fwd_src | output | SRC_W | Originating source of the forwarded request |
| fwd_addr | output | ADDR_W | Line address of the forwarded request |
| fwd_wb | output | 1 | Forwarded request is a writeback |
| cmp_valid | input | 1 | Source reports all snoop responses collected |
| cmp_addr | input | ADDR_W | Line that the completion notice releases |
| wbd_valid | input | 1 | Writeback data beat valid |
| wbd_src | input | SRC_W | Writer of the data beat |
| wbd_addr | input | ADDR_W | Line address of the data beat |
| wbd_data | input | DATA_W | Writeback data |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| ack_valid | output | 1 | Writeback acknowledgement valid |
| ack_dst | output | SRC_W | Node that receives the acknowledgement |

## Verification
The stimulus keeps addresses within four lines, so that several sources regularly ask for the same line at once. A design that forwards two same-line requests before a release would show up as an unexpected `req_ready`, and a priority pointer that is not updated would grant the wrong source out of several eligible ones. Completion notices are sent both for locked lines and for unlocked ones, sometimes in the same cycle as an acceptance of that line. A table that lets the clear override the set would unlock a line too early, and one that decodes the address wrongly would release a neighbouring line. Writeback data beats arrive at random times, so that an acknowledgement issued before the memory write, or sent to the wrong node, is caught.

// File: rtl/hrs_pkg.sv
// Shared types for the home request serializer.
// Assumes: request kinds are encoded in a single bit.
package hrs_pkg;
    typedef enum logic {
        KIND_READ = 1'b0,
        KIND_WB   = 1'b1
    } req_kind_e;
endpackage

// File: rtl/hrs_rr_arbiter.sv
// Round-robin arbiter: grants the first requester after the last winner.
// Assumes: req is sampled combinationally; pointer advances only on a grant.
module hrs_rr_arbiter #(
    parameter int N     = 3,
    localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic [IDXW-1:0] gnt_idx,
    output logic         gnt_any
);
    logic [IDXW-1:0] last_q;

    // Search the requesters in cyclic order starting after the last winner.
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int off = 1; off <= N; off++) begin
            int idx;
            idx = (int'(last_q) + off) % N;
            if (!gnt_any && req[idx]) begin
                gnt_any     = 1'b1;
                gnt[idx]    = 1'b1;
                gnt_idx     = IDXW'(idx);
            end
        end
    end

    // Remember the winner; reset makes source 0 the first choice.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= IDXW'(N - 1);
        else if (gnt_any)
            last_q <= gnt_idx;
    end
endmodule

// File: rtl/hrs_lock_table.sv
// One lock flag per line address: set on forward, cleared on completion.
// Assumes: a set and a clear of the same line in one cycle leave it locked.
module hrs_lock_table #(
    parameter int ADDR_W = 4,
    localparam int NLINE = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              clr_en,
    input  logic [ADDR_W-1:0] clr_addr,
    output logic [NLINE-1:0]  locked
);
    // Update each flag; the set has priority over the clear.
    for (genvar g = 0; g < NLINE; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n)
                locked[g] <= 1'b0;
            else if (set_en && set_addr == ADDR_W'(g))
                locked[g] <= 1'b1;
            else if (clr_en && clr_addr == ADDR_W'(g))
                locked[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/hrs_wb_path.sv
// Writeback data path: memory write one cycle after data, ack one after that.
// Assumes: memory accepts a write every cycle; no backpressure on acks.
module hrs_wb_path #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int SRC_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wbd_valid,
    input  logic [SRC_W-1:0]  wbd_src,
    input  logic [ADDR_W-1:0] wbd_addr,
    input  logic [DATA_W-1:0] wbd_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              ack_valid,
    output logic [SRC_W-1:0]  ack_dst
);
    logic [SRC_W-1:0] wr_src_q;

    // Stage 1: register the memory write and keep the writer's number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            wr_src_q  <= '0;
        end else begin
            mem_we    <= wbd_valid;
            mem_addr  <= wbd_addr;
            mem_wdata <= wbd_data;
            wr_src_q  <= wbd_src;
        end
    end

    // Stage 2: acknowledge the writer once its write has been issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid <= 1'b0;
            ack_dst   <= '0;
        end else begin
            ack_valid <= mem_we;
            ack_dst   <= wr_src_q;
        end
    end
endmodule

// File: rtl/hrs_serializer.sv
// Home request serializer: orders same-line requests from several sources,
// broadcasts the winner, and locks the line until the source's completion
// notice (relaxed: data phase may still be open). Also runs writebacks.
// Assumes: sources hold a request until accepted; completions are well formed.
module hrs_serializer #(
    parameter int N_SRC  = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int NLINE = 1 << ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_SRC-1:0]        req_valid,
    input  logic [N_SRC*ADDR_W-1:0] req_addr,
    input  logic [N_SRC-1:0]        req_wb,
    output logic [N_SRC-1:0]        req_ready,
    output logic                    fwd_valid,
    output logic [SRC_W-1:0]        fwd_src,
    output logic [ADDR_W-1:0]       fwd_addr,
    output logic                    fwd_wb,
    input  logic                    cmp_valid,
    input  logic [ADDR_W-1:0]       cmp_addr,
    input  logic                    wbd_valid,
    input  logic [SRC_W-1:0]        wbd_src,
    input  logic [ADDR_W-1:0]       wbd_addr,
    input  logic [DATA_W-1:0]       wbd_data,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    output logic                    ack_valid,
    output logic [SRC_W-1:0]        ack_dst
);
    import hrs_pkg::*;

    logic [NLINE-1:0]  locked;
    logic [N_SRC-1:0]  eligible;
    logic [N_SRC-1:0]  gnt;
    logic [SRC_W-1:0]  gnt_idx;
    logic              gnt_any;
    logic [ADDR_W-1:0] win_addr;
    req_kind_e         win_kind;

    // A source is eligible when it offers a request to an unlocked line.
    for (genvar s = 0; s < N_SRC; s++) begin : g_elig
        assign eligible[s] = req_valid[s] && !locked[req_addr[s*ADDR_W +: ADDR_W]];
    end

    hrs_rr_arbiter #(.N(N_SRC)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (eligible),
        .gnt     (gnt),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
    );

    assign req_ready = gnt;

    // Select the address and kind of the winning source.
    always_comb begin
        win_addr = '0;
        win_kind = KIND_READ;
        for (int s = 0; s < N_SRC; s++) begin
            if (gnt[s]) begin
                win_addr = req_addr[s*ADDR_W +: ADDR_W];
                win_kind = req_kind_e'(req_wb[s]);
            end
        end
    end

    hrs_lock_table #(.ADDR_W(ADDR_W)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (gnt_any),
        .set_addr (win_addr),
        .clr_en   (cmp_valid),
        .clr_addr (cmp_addr),
        .locked   (locked)
    );

    // Register the forwarded snoop broadcast to all nodes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            fwd_src   <= '0;
            fwd_addr  <= '0;
            fwd_wb    <= 1'b0;
        end else begin
            fwd_valid <= gnt_any;
            fwd_src   <= gnt_idx;
            fwd_addr  <= win_addr;
            fwd_wb    <= (win_kind == KIND_WB);
        end
    end

    hrs_wb_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_W(SRC_W)) u_wb (
        .clk       (clk),
        .rst_n     (rst_n),
        .wbd_valid (wbd_valid),
        .wbd_src   (wbd_src),
        .wbd_addr  (wbd_addr),
        .wbd_data  (wbd_data),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .ack_valid (ack_valid),
        .ack_dst   (ack_dst)
    );
endmodule

// File: rtl/hrs_serializer_chk.sv
// Property checker for the serializer, kept beside it and bound in below.
// Assumes: observes ports only; keeps its own shadow of locked lines.
module hrs_serializer_chk #(
    parameter int N_SRC  = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int NLINE = 1 << ADDR_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N_SRC-1:0]        req_valid,
    input logic [N_SRC*ADDR_W-1:0] req_addr,
    input logic [N_SRC-1:0]        req_ready,
    input logic                    fwd_valid,
    input logic [ADDR_W-1:0]       fwd_addr,
    input logic                    cmp_valid,
    input logic [ADDR_W-1:0]       cmp_addr,
    input logic                    wbd_valid,
    input logic [ADDR_W-1:0]       wbd_addr,
    input logic                    mem_we,
    input logic [ADDR_W-1:0]       mem_addr,
    input logic                    ack_valid
);
    logic [NLINE-1:0]  shadow;
    logic              acc;
    logic [ADDR_W-1:0] acc_addr;
    logic              acc_on_locked;

    // Find the accepted address from the ready bits.
    always_comb begin
        acc = 1'b0;
        acc_addr = '0;
        for (int s = 0; s < N_SRC; s++) begin
            if (req_ready[s]) begin
                acc = 1'b1;
                acc_addr = req_addr[s*ADDR_W +: ADDR_W];
            end
        end
        acc_on_locked = acc && shadow[acc_addr];
    end

    // Shadow lock state rebuilt from port activity.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shadow <= '0;
        else begin
            if (cmp_valid) shadow[cmp_addr] <= 1'b0;
            if (acc)       shadow[acc_addr] <= 1'b1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!fwd_valid && !mem_we && !ack_valid));
    p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));
    p_ready_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0);
    p_fwd_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (fwd_valid && fwd_addr == $past(acc_addr)));
    p_no_spurious_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !fwd_valid);
    p_locked_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_on_locked);
    p_mem_after_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wbd_valid |=> (mem_we && mem_addr == $past(wbd_addr)));
    p_ack_after_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> ack_valid);
endmodule

bind hrs_serializer hrs_serializer_chk #(
    .N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
    .cmp_valid(cmp_valid), .cmp_addr(cmp_addr), .wbd_valid(wbd_valid),
    .wbd_addr(wbd_addr), .mem_we(mem_we), .mem_addr(mem_addr),
    .ack_valid(ack_valid)
);

// File: tb/sim_hrs_serializer.sv
module sim_hrs_serializer;
    localparam int CLK_P  = 10;
    localparam int NS     = 3;
    localparam int AW     = 4;
    localparam int DW     = 8;
    localparam int SW     = 2;
    localparam int CYCLES = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0]    req_valid = '0;
    logic [NS*AW-1:0] req_addr = '0;
    logic [NS-1:0]    req_wb = '0;
    logic [NS-1:0]    req_ready;
    logic             fwd_valid, fwd_wb;
    logic [SW-1:0]    fwd_src;
    logic [AW-1:0]    fwd_addr;
    logic             cmp_valid = 1'b0;
    logic [AW-1:0]    cmp_addr = '0;
    logic             wbd_valid = 1'b0;
    logic [SW-1:0]    wbd_src = '0;
    logic [AW-1:0]    wbd_addr = '0;
    logic [DW-1:0]    wbd_data = '0;
    logic             mem_we, ack_valid;
    logic [AW-1:0]    mem_addr;
    logic [DW-1:0]    mem_wdata;
    logic [SW-1:0]    ack_dst;

    int errors = 0;
    int checks = 0;

    // bench model state
    bit pend_v[NS];
    int pend_a[NS];
    bit pend_w[NS];
    bit lock_m[16];
    int last_g;
    bit e_fv; int e_fs; int e_fa; bit e_fw;
    bit e_mw; int e_ma; int e_md; int e_ms;
    bit e_av; int e_ad;

    always #(CLK_P/2) clk = ~clk;

    hrs_serializer #(.N_SRC(NS), .ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_wb(req_wb), .req_ready(req_ready), .fwd_valid(fwd_valid),
        .fwd_src(fwd_src), .fwd_addr(fwd_addr), .fwd_wb(fwd_wb),
        .cmp_valid(cmp_valid), .cmp_addr(cmp_addr), .wbd_valid(wbd_valid),
        .wbd_src(wbd_src), .wbd_addr(wbd_addr), .wbd_data(wbd_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .ack_valid(ack_valid), .ack_dst(ack_dst)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Expected winner from the requirements: first eligible after last_g.
    function automatic int exp_winner();
        for (int off = 1; off <= NS; off++) begin
            int idx;
            idx = (last_g + off) % NS;
            if (pend_v[idx] && !lock_m[pend_a[idx]]) return idx;
        end
        return -1;
    endfunction

    function automatic int count_eligible();
        int n;
        n = 0;
        for (int s = 0; s < NS; s++)
            if (pend_v[s] && !lock_m[pend_a[s]]) n++;
        return n;
    endfunction

    function automatic bit any_locked();
        for (int a = 0; a < 16; a++) if (lock_m[a]) return 1'b1;
        return 1'b0;
    endfunction

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int s = 0; s < NS; s++) begin pend_v[s] = 0; pend_a[s] = 0; pend_w[s] = 0; end
        for (int a = 0; a < 16; a++) lock_m[a] = 0;
        last_g = NS - 1;
        e_fv = 0; e_fs = 0; e_fa = 0; e_fw = 0;
        e_mw = 0; e_ma = 0; e_md = 0; e_ms = 0; e_av = 0; e_ad = 0;

        repeat (3) @(negedge clk);
        // R1: outputs idle during reset
        chk("R1", "fwd_valid in reset", int'(fwd_valid), 0);
        chk("R1", "mem_we in reset", int'(mem_we), 0);
        chk("R1", "ack_valid in reset", int'(ack_valid), 0);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < CYCLES; cyc++) begin
            int g; int ne; bit cv; int ca;
            @(negedge clk);
            // forward outputs from the previous cycle's acceptance
            chk("R9", "fwd_valid", int'(fwd_valid), int'(e_fv));
            if (e_fv) begin
                chk("R2", "fwd_src", int'(fwd_src), e_fs);
                chk("R2", "fwd_addr", int'(fwd_addr), e_fa);
                chk("R6", "fwd_wb", int'(fwd_wb), int'(e_fw));
            end
            chk("R7", "mem_we", int'(mem_we), int'(e_mw));
            if (e_mw) begin
                chk("R7", "mem_addr", int'(mem_addr), e_ma);
                chk("R7", "mem_wdata", int'(mem_wdata), e_md);
            end
            chk("R7", "ack_valid", int'(ack_valid), int'(e_av));
            if (e_av) chk("R7", "ack_dst", int'(ack_dst), e_ad);
            if (cyc == 0) chk("R1", "fwd_valid after reset", int'(fwd_valid), 0);

            // new stimulus
            if (cyc == 0) begin
                // directed: all sources contend for line 2, source 1 writes back
                for (int s = 0; s < NS; s++) begin
                    pend_v[s] = 1; pend_a[s] = 2; pend_w[s] = (s == 1);
                end
            end else begin
                for (int s = 0; s < NS; s++) begin
                    if (!pend_v[s] && ($urandom % 3 == 0)) begin
                        pend_v[s] = 1;
                        pend_a[s] = $urandom % 4;
                        pend_w[s] = ($urandom % 4 == 0);
                    end
                end
            end
            cv = (cyc > 4) && ($urandom % 3 == 0);
            ca = $urandom % 4;
            cmp_valid = cv;
            cmp_addr = AW'(ca);
            wbd_valid = ($urandom % 4 == 0);
            wbd_src = SW'($urandom % NS);
            wbd_addr = AW'($urandom);
            wbd_data = DW'($urandom);
            for (int s = 0; s < NS; s++) begin
                req_valid[s] = pend_v[s];
                req_addr[s*AW +: AW] = AW'(pend_a[s]);
                req_wb[s] = pend_w[s];
            end
            #1;

            g = exp_winner();
            ne = count_eligible();
            for (int s = 0; s < NS; s++) begin
                int er;
                er = (s == g) ? 1 : 0;
                if (pend_v[s] && lock_m[pend_a[s]]) begin
                    if (cv && ca != pend_a[s]) chk("R8", "ready on line still locked", int'(req_ready[s]), er);
                    else if (pend_w[s])        chk("R6", "ready on locked line (wb)", int'(req_ready[s]), er);
                    else                       chk("R3", "ready on locked line", int'(req_ready[s]), er);
                end else if (ne > 1) begin
                    chk("R5", "round-robin ready", int'(req_ready[s]), er);
                end else if (pend_v[s] && any_locked()) begin
                    chk("R4", "ready on free line", int'(req_ready[s]), er);
                end else begin
                    chk("R2", "ready", int'(req_ready[s]), er);
                end
            end

            // advance model to the coming clock edge
            e_av = e_mw; e_ad = e_ms;
            e_mw = wbd_valid; e_ma = int'(wbd_addr); e_md = int'(wbd_data); e_ms = int'(wbd_src);
            if (cv) lock_m[ca] = 0;
            e_fv = (g >= 0);
            if (g >= 0) begin
                e_fs = g; e_fa = pend_a[g]; e_fw = pend_w[g];
                lock_m[pend_a[g]] = 1;
                last_g = g;
                pend_v[g] = 0;
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule